// File: doc/BRIEF.md
# Masked Event Status and Interrupt Register

This block holds the event status word of a flash controller together with its interrupt mask, and derives one interrupt line from them. Event pulses from elsewhere in the controller set individual status bits. Software clears bits by writing ones through a write-one-to-clear port. It writes the mask through a separate control write port. A mask bit at one disables its source.

Thirteen status bits exist. The low twelve can be cleared and masked. Their positions are:

| Bit | Meaning |
|-----|---------|
| 0 | command-write request |
| 1 | read-data request |
| 2 | write-data request |
| 3 | correctable ECC error |
| 4 | uncorrectable ECC error |
| 5 | bad block on chip select 1 |
| 6 | bad block on chip select 0 |
| 7 | command done on chip select 1 |
| 8 | command done on chip select 0 |
| 9 | page done on chip select 1 |
| 10 | page done on chip select 0 |
| 11 | flash ready |

The top bit, 12, reports controller ready. It is set-only and never reaches the interrupt.

A small state machine follows the controller clock enable `clk_on`. It has three states:

- **RUN**: normal updates.
- **GATED**: the clock is off, so every register holds.
- **WAKE**: a one-cycle state after the clock returns, in which the status word is loaded with 0x1800.

Its transitions are:

- RUN→GATED when `clk_on` is low.
- GATED→WAKE when `clk_on` is high.
- WAKE→RUN unconditionally.
- GATED stays in GATED while `clk_on` is low.
- RUN stays in RUN while `clk_on` is high.

Top module: `evt_irq_status`

## Requirements
- R1: After reset the status word is 0x0000, the mask is 0xFFF (all sources disabled) and `irq` is low.
- R2: In RUN, a one on `evt_set[i]` (i = 0..12) sets status bit i at the next clock edge; other bits keep their value.
- R3: In RUN, a status write clears each bit 0..11 whose write-data bit is one; write-data zeros leave bits unchanged.
- R4: Status bit 12 is never cleared by the write port and never falls after reset.
- R5: When an event and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R6: In RUN, a control write loads `ctl_mask_wdata` into the 12-bit mask at the next edge; a mask bit of one stops the matching status bit from raising `irq`.
- R7: `irq` is high exactly when some status bit 0..11 is set and its mask bit is zero; bit 12 never raises `irq`.
- R8: While the state machine is in GATED, events, status writes and control writes have no effect; the status word and mask hold.
- R9: One cycle after `clk_on` returns high (state WAKE), the status word becomes exactly 0x1800 regardless of events or writes in those cycles; the mask keeps its value.
- R10: WAKE lasts one cycle; from the following cycle, events set bits again as in R2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_on | input | 1 | Controller clock enable; low means the clock is gated off |
| evt_set | input | 13 | Per-bit event set pulses |
| sts_we | input | 1 | Status write strobe (write-one-to-clear) |
| sts_wdata | input | 13 | Status write data; ones clear bits 0..11 |
| ctl_we | input | 1 | Control (mask) write strobe |
| ctl_mask_wdata | input | 12 | New mask value; one disables a source |
| sts_q | output | 13 | Status word |
| mask_q | output | 12 | Interrupt mask |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: twelve clearable bits and a reset mask of all ones. With these values every named status position can be set and cleared one at a time. The fixed wake value 0x1800 lands on real bit positions, so the flash-ready bit reaches the interrupt after a clock restart once the mask opens it. The bench also uses the all-ones reset mask to prove that no interrupt appears while sources are still disabled.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;

    // Number of status bits that software may clear and mask.
    localparam int unsigned W1C_BITS = 12;
    // Full status width: the clearable bits plus the set-only ready bit.
    localparam int unsigned STS_BITS = W1C_BITS + 1;

    // State of the clock-gate tracker.
    typedef enum logic [1:0] {
        GS_RUN   = 2'd0,
        GS_GATED = 2'd1,
        GS_WAKE  = 2'd2
    } gate_state_e;

    // Update command the tracker hands to the registers.
    typedef enum logic [1:0] {
        UPD_NORMAL = 2'd0,
        UPD_FREEZE = 2'd1,
        UPD_WAKE   = 2'd2
    } upd_mode_e;

endpackage

// File: rtl/evt_irq_gate_fsm.sv
module evt_irq_gate_fsm
    import evt_irq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clk_on,
    output gate_state_e state_q,
    output upd_mode_e   upd_mode
);

    gate_state_e state_d;

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GS_RUN:   if (!clk_on) state_d = GS_GATED;
            GS_GATED: if (clk_on)  state_d = GS_WAKE;
            GS_WAKE:               state_d = GS_RUN;
            default:               state_d = GS_RUN;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= GS_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    // Output decode.
    always_comb begin
        upd_mode = UPD_NORMAL;
        unique case (state_q)
            GS_RUN:   upd_mode = UPD_NORMAL;
            GS_GATED: upd_mode = UPD_FREEZE;
            GS_WAKE:  upd_mode = UPD_WAKE;
            default:  upd_mode = UPD_FREEZE;
        endcase
    end

endmodule

// File: rtl/evt_irq_status_reg.sv
module evt_irq_status_reg
    import evt_irq_pkg::*;
#(
    parameter int unsigned W1C_W = W1C_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  upd_mode_e         upd_mode,
    input  logic [W1C_W:0]    evt_set,
    input  logic              sts_we,
    input  logic [W1C_W:0]    sts_wdata,
    output logic [W1C_W:0]    sts_q
);

    localparam int unsigned STS_W = W1C_W + 1;

    // After a clock restart both ready flags read as set:
    // the top clearable bit (flash ready) and the set-only bit (controller ready).
    localparam logic [STS_W-1:0] WAKE_VALUE =
        (STS_W'(1) << W1C_W) | (STS_W'(1) << (W1C_W - 1));

    // Clearable bits: an event set beats a same-cycle clear.
    for (genvar gi = 0; gi < W1C_W; gi++) begin : g_w1c
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sts_q[gi] <= 1'b0;
            end else begin
                unique case (upd_mode)
                    UPD_NORMAL: begin
                        if (evt_set[gi]) begin
                            sts_q[gi] <= 1'b1;
                        end else if (sts_we && sts_wdata[gi]) begin
                            sts_q[gi] <= 1'b0;
                        end
                    end
                    UPD_WAKE:   sts_q[gi] <= WAKE_VALUE[gi];
                    UPD_FREEZE: sts_q[gi] <= sts_q[gi];
                    default:    sts_q[gi] <= sts_q[gi];
                endcase
            end
        end
    end

    // Set-only controller-ready bit: the write port cannot clear it.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sts_q[W1C_W] <= 1'b0;
        end else begin
            unique case (upd_mode)
                UPD_NORMAL: if (evt_set[W1C_W]) sts_q[W1C_W] <= 1'b1;
                UPD_WAKE:   sts_q[W1C_W] <= WAKE_VALUE[W1C_W];
                UPD_FREEZE: sts_q[W1C_W] <= sts_q[W1C_W];
                default:    sts_q[W1C_W] <= sts_q[W1C_W];
            endcase
        end
    end

endmodule

// File: rtl/evt_irq_mask_irq.sv
module evt_irq_mask_irq
    import evt_irq_pkg::*;
#(
    parameter int unsigned          W1C_W    = W1C_BITS,
    parameter logic [W1C_W-1:0]     MASK_RST = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  upd_mode_e         upd_mode,
    input  logic              ctl_we,
    input  logic [W1C_W-1:0]  ctl_mask_wdata,
    input  logic [W1C_W:0]    sts_q,
    output logic [W1C_W-1:0]  mask_q,
    output logic              irq
);

    logic [W1C_W-1:0] pending;

    // The mask only loads while the clock is running normally.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= MASK_RST;
        end else if (upd_mode == UPD_NORMAL && ctl_we) begin
            mask_q <= ctl_mask_wdata;
        end
    end

    // A mask bit of one disables its source.
    // The set-only ready bit is excluded from the interrupt.
    always_comb begin
        pending = sts_q[W1C_W-1:0] & ~mask_q;
        irq     = |pending;
    end

endmodule

// File: rtl/evt_irq_status.sv
module evt_irq_status
    import evt_irq_pkg::*;
#(
    parameter int unsigned      W1C_W    = W1C_BITS,
    parameter logic [W1C_W-1:0] MASK_RST = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_on,
    input  logic [W1C_W:0]    evt_set,
    input  logic              sts_we,
    input  logic [W1C_W:0]    sts_wdata,
    input  logic              ctl_we,
    input  logic [W1C_W-1:0]  ctl_mask_wdata,
    output logic [W1C_W:0]    sts_q,
    output logic [W1C_W-1:0]  mask_q,
    output logic              irq
);

    gate_state_e gate_state;
    upd_mode_e   upd_mode;

    evt_irq_gate_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .clk_on   (clk_on),
        .state_q  (gate_state),
        .upd_mode (upd_mode)
    );

    evt_irq_status_reg #(
        .W1C_W (W1C_W)
    ) u_sts (
        .clk       (clk),
        .rst_n     (rst_n),
        .upd_mode  (upd_mode),
        .evt_set   (evt_set),
        .sts_we    (sts_we),
        .sts_wdata (sts_wdata),
        .sts_q     (sts_q)
    );

    evt_irq_mask_irq #(
        .W1C_W    (W1C_W),
        .MASK_RST (MASK_RST)
    ) u_mask (
        .clk            (clk),
        .rst_n          (rst_n),
        .upd_mode       (upd_mode),
        .ctl_we         (ctl_we),
        .ctl_mask_wdata (ctl_mask_wdata),
        .sts_q          (sts_q),
        .mask_q         (mask_q),
        .irq            (irq)
    );

endmodule

// File: rtl/evt_irq_status_chk.sv
module evt_irq_status_chk
    import evt_irq_pkg::*;
#(
    parameter int unsigned W1C_W = W1C_BITS
) (
    input logic             clk,
    input logic             rst_n,
    input gate_state_e      gate_state,
    input logic [W1C_W:0]   evt_set,
    input logic             sts_we,
    input logic [W1C_W:0]   sts_wdata,
    input logic [W1C_W:0]   sts_q,
    input logic [W1C_W-1:0] mask_q
);

    localparam int unsigned STS_W = W1C_W + 1;
    localparam logic [STS_W-1:0] WAKE_VALUE =
        (STS_W'(1) << W1C_W) | (STS_W'(1) << (W1C_W - 1));

    AST_EVT_SETS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_state == GS_RUN && evt_set != '0) |=> ((sts_q & $past(evt_set)) == $past(evt_set))); // R5

    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_state == GS_RUN && sts_we) |=>
            ((sts_q[W1C_W-1:0] & $past(sts_wdata[W1C_W-1:0] & ~evt_set[W1C_W-1:0])) == '0)); // R3

    AST_CTRL_RDY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(sts_q[W1C_W])); // R4

    AST_GATED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_state == GS_GATED) |=> ($stable(sts_q) && $stable(mask_q))); // R8

    AST_WAKE_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_state == GS_WAKE) |=> (sts_q == WAKE_VALUE)); // R9

    AST_WAKE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_state == GS_WAKE) |=> (gate_state == GS_RUN)); // R10

endmodule

bind evt_irq_status evt_irq_status_chk #(.W1C_W(W1C_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .gate_state (gate_state),
    .evt_set    (evt_set),
    .sts_we     (sts_we),
    .sts_wdata  (sts_wdata),
    .sts_q      (sts_q),
    .mask_q     (mask_q)
);

// File: tb/evt_irq_status_tb_top.sv
module evt_irq_status_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clk_on = 1'b1;
    logic [12:0] evt_set = '0;
    logic        sts_we = 1'b0;
    logic [12:0] sts_wdata = '0;
    logic        ctl_we = 1'b0;
    logic [11:0] ctl_mask_wdata = '0;
    logic [12:0] sts_q;
    logic [11:0] mask_q;
    logic        irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    evt_irq_status dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .clk_on         (clk_on),
        .evt_set        (evt_set),
        .sts_we         (sts_we),
        .sts_wdata      (sts_wdata),
        .ctl_we         (ctl_we),
        .ctl_mask_wdata (ctl_mask_wdata),
        .sts_q          (sts_q),
        .mask_q         (mask_q),
        .irq            (irq)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    // One clock edge, then settle away from it and drop the strobes.
    task automatic tick();
        @(posedge clk);
        #1;
        evt_set = '0;
        sts_we  = 1'b0;
        sts_wdata = '0;
        ctl_we  = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 status", sts_q, 32'h0);
        chk("R1 mask", mask_q, 32'hFFF);
        chk("R1 irq", irq, 32'h0);
    endtask

    task automatic t_set_each();
        logic [12:0] exp = '0;
        for (int i = 0; i < 12; i++) begin
            evt_set = 13'(1) << i;
            tick();
            exp[i] = 1'b1;
            chk("R2 single set", sts_q, exp);
        end
        sts_we = 1'b1; sts_wdata = 13'h0FFF;
        tick();
        chk("R3 clear all low", sts_q, 32'h0);
        chk("R1 masked no irq", irq, 32'h0);
    endtask

    task automatic t_w1c();
        evt_set = 13'h1FFF;
        tick();
        chk("R2 set all", sts_q, 32'h1FFF);
        sts_we = 1'b1; sts_wdata = 13'h0;
        tick();
        chk("R3 zeros no effect", sts_q, 32'h1FFF);
        sts_we = 1'b1; sts_wdata = 13'h00A5;
        tick();
        chk("R3 partial clear", sts_q, 32'h1F5A);
        sts_wdata = 13'h00A5;
        tick();
        chk("R3 data without strobe", sts_q, 32'h1F5A);
        sts_we = 1'b1; sts_wdata = 13'h1FFF;
        tick();
        chk("R4 bit12 kept", sts_q, 32'h1000);
    endtask

    task automatic t_set_wins();
        evt_set = 13'h0018;
        tick();
        evt_set = 13'h0008; sts_we = 1'b1; sts_wdata = 13'h0018;
        tick();
        chk("R5 set beats clear", sts_q, 32'h1008);
        sts_we = 1'b1; sts_wdata = 13'h0008;
        tick();
        chk("R3 cleared after", sts_q, 32'h1000);
    endtask

    task automatic t_mask();
        chk("R7 bit12 no irq", irq, 32'h0);
        ctl_we = 1'b1; ctl_mask_wdata = 12'h000;
        tick();
        chk("R6 mask load", mask_q, 32'h000);
        chk("R7 bit12 unmasked no irq", irq, 32'h0);
        evt_set = 13'h0004;
        tick();
        chk("R7 unmasked irq", irq, 32'h1);
        ctl_we = 1'b1; ctl_mask_wdata = 12'h004;
        tick();
        chk("R6 masked suppress", irq, 32'h0);
        ctl_we = 1'b1; ctl_mask_wdata = 12'hFFB;
        tick();
        chk("R7 only bit2 open", irq, 32'h1);
        sts_we = 1'b1; sts_wdata = 13'h0004;
        tick();
        chk("R7 cleared no irq", irq, 32'h0);
        evt_set = 13'h0004;
        ctl_we = 1'b1; ctl_mask_wdata = 12'h7FF;
        tick();
        chk("R6 mask 7FF", mask_q, 32'h7FF);
        chk("R6 bit2 masked", irq, 32'h0);
    endtask

    task automatic t_gate_wake();
        clk_on = 1'b0;
        tick();
        evt_set = 13'h0FF0; sts_we = 1'b1; sts_wdata = 13'h1FFF;
        ctl_we = 1'b1; ctl_mask_wdata = 12'h000;
        tick();
        chk("R8 status held", sts_q, 32'h1004);
        chk("R8 mask held", mask_q, 32'h7FF);
        chk("R8 irq", irq, 32'h0);
        clk_on = 1'b1;
        evt_set = 13'h0001;
        tick();
        evt_set = 13'h0001; sts_we = 1'b1; sts_wdata = 13'h0800;
        tick();
        chk("R9 wake value", sts_q, 32'h1800);
        chk("R9 mask kept", mask_q, 32'h7FF);
        chk("R9 flash ready irq", irq, 32'h1);
        evt_set = 13'h0001;
        tick();
        chk("R10 run again", sts_q, 32'h1801);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        t_set_each();
        t_w1c();
        t_set_wins();
        t_mask();
        t_gate_wake();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        #100000;
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule